// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a general-purpose I/O port with sixteen pins behind a sixteen-bit register bus. Software configures each pin as an input or an output. It writes the output data and picks, for every pin, whether a rising or a falling edge counts as an event. Events on unmasked input pins set sticky status bits. One interrupt line stays high while any status bit is set. Software clears status bits by writing ones to them.

External levels enter through a two-stage synchronizer. A registered copy of the synchronized value, one cycle older, supplies the edge comparison. A pin-enable register gates what the data-input register reads back. Read data is registered and appears one cycle after the read strobe. A bus access flagged as narrower than sixteen bits is rejected: a narrow read returns zero and a narrow write changes nothing.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the data-output, direction, edge-select, mask and pin-enable registers read 0xFFFF. Status and data-input read 0x0000. `pins_out` and `irq` are 0.
- R2: The register offsets are 0x00 data input (read-only), 0x04 data output, 0x08 direction, 0x0C edge select, 0x10 mask, 0x14 status and 0x18 pin enable. Any other offset reads 0x0000, and writes to it change no register.
- R3: A read of offset 0x00 returns the synchronized inputs ANDed with the pin-enable register. A write to offset 0x00 has no effect.
- R4: `pins_out` equals data-output AND NOT direction (direction bit 1 = input). It takes its new value on the same clock edge that writes either register.
- R5: Edge-select bit 1 means a 0-to-1 input change is an event, and bit 0 means a 1-to-0 change is an event. The opposite change on that pin sets nothing. The status bit is set on the third rising clock edge after the input changes.
- R6: An event sets its status bit only when that pin's direction bit is 1 and its mask bit is 0.
- R7: Writing the status offset clears each status bit written as 1 and leaves bits written as 0 unchanged. `irq` is the OR of all status bits and updates on the same edge as the status.
- R8: When an event and a clear of the same status bit fall on the same clock edge, the bit stays set.
- R9: An access with `bus_wide` = 0 is rejected. A narrow read returns 0x0000, and a narrow write changes no register.
- R10: `rdata` holds the addressed register one clock edge after a read is accepted. It is 0x0000 in every cycle after an edge with no accepted read. A read and a write on the same edge return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 = full sixteen-bit access; 0 = narrow access, rejected |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Registered read data |
| pins_in | input | NPINS | Asynchronous external input levels |
| pins_out | output | NPINS | Output line levels |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The bench builds the port with its defaults: sixteen pins, an eight-bit offset and a two-stage synchronizer. At those values every register bit and every mapped and unmapped offset can be driven with full-width patterns. The bench runs a behavioural model alongside the design. The model keeps a queue of input samples, which fixes the exact cycle in which each status bit must rise. That makes the three-edge event latency and the event-versus-clear collision checkable at a single clock edge. The pin mix covers rising and falling selection on neighbouring pins, masked pins, pins set as outputs, and partial write-one-to-clear patterns.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

  // Width of the decoded offset field; wider buses must keep upper bits zero
  localparam int OFS_W = 8;

  typedef enum logic [2:0] {
    SEL_DIN,
    SEL_DOUT,
    SEL_DIR,
    SEL_EDGE,
    SEL_MASK,
    SEL_STAT,
    SEL_PEN,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [OFS_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      8'h00:   sel = SEL_DIN;
      8'h04:   sel = SEL_DOUT;
      8'h08:   sel = SEL_DIR;
      8'h0C:   sel = SEL_EDGE;
      8'h10:   sel = SEL_MASK;
      8'h14:   sel = SEL_STAT;
      8'h18:   sel = SEL_PEN;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_async,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] chain [SYNC_STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= pins_async;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[SYNC_STAGES-1];
    end
  end

  assign sync_o = chain[SYNC_STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_status.sv
`timescale 1ns/1ps
module gpio_evt_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);

  logic [W-1:0] ev;
  logic [W-1:0] clr_eff;
  logic [W-1:0] st_n;
  logic [W-1:0] st_q;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic went_up, went_down;
    assign went_up   = cur_i[i] & ~prev_i[i];
    assign went_down = ~cur_i[i] & prev_i[i];
    assign ev[i] = dir_i[i] & ~mask_i[i] & (rise_sel_i[i] ? went_up : went_down);
  end

  assign clr_eff = clr_we_i ? clr_bits_i : '0;
  // a fresh event overrides a clear of the same bit
  assign st_n    = (st_q & ~clr_eff) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      irq_q <= |st_n;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R5 R8
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));

  // R6
  blocked_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & ~$past(st_q) & ($past(mask_i) | ~$past(dir_i))) == '0));

  // R7
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(st_q) & ~st_q & ~$past(clr_eff)) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pins_in,
  output logic [NPINS-1:0]  pins_out,
  output logic              irq
);

  localparam logic [NPINS-1:0] ONES = {NPINS{1'b1}};

  logic [NPINS-1:0] dout_q, dir_q, edge_q, mask_q, pen_q;
  logic [NPINS-1:0] dout_n, dir_n, edge_n, mask_n, pen_n;
  logic [NPINS-1:0] sync_w, prev_w, status_w;
  logic [NPINS-1:0] rd_mux;
  logic [NPINS-1:0] rdata_q, pins_q;
  logic             hi_zero;
  logic             wr_ok, rd_ok, clr_we;
  reg_sel_e         sel;

  // offsets above the decoded field must be zero (ADDR_W >= OFS_W assumed)
  if (ADDR_W > OFS_W) begin : g_hi_addr
    assign hi_zero = (addr[ADDR_W-1:OFS_W] == '0);
  end else begin : g_no_hi_addr
    assign hi_zero = 1'b1;
  end

  assign sel    = hi_zero ? decode_offset(addr[OFS_W-1:0]) : SEL_NONE;
  assign wr_ok  = wr_en & bus_wide;
  assign rd_ok  = rd_en & bus_wide;
  assign clr_we = wr_ok && (sel == SEL_STAT);

  gpio_in_sync #(.W(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pins_async (pins_in),
    .sync_o     (sync_w),
    .prev_o     (prev_w)
  );

  gpio_evt_status #(.W(NPINS)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .cur_i      (sync_w),
    .prev_i     (prev_w),
    .rise_sel_i (edge_q),
    .dir_i      (dir_q),
    .mask_i     (mask_q),
    .clr_we_i   (clr_we),
    .clr_bits_i (wdata),
    .status_o   (status_w),
    .irq_o      (irq)
  );

  always_comb begin
    dout_n = dout_q;
    dir_n  = dir_q;
    edge_n = edge_q;
    mask_n = mask_q;
    pen_n  = pen_q;
    if (wr_ok) begin
      case (sel)
        SEL_DOUT: dout_n = wdata;
        SEL_DIR:  dir_n  = wdata;
        SEL_EDGE: edge_n = wdata;
        SEL_MASK: mask_n = wdata;
        SEL_PEN:  pen_n  = wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DIN:  rd_mux = sync_w & pen_q;
      SEL_DOUT: rd_mux = dout_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_EDGE: rd_mux = edge_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = status_w;
      SEL_PEN:  rd_mux = pen_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= ONES;
      dir_q   <= ONES;
      edge_q  <= ONES;
      mask_q  <= ONES;
      pen_q   <= ONES;
      pins_q  <= '0;
      rdata_q <= '0;
    end else begin
      dout_q  <= dout_n;
      dir_q   <= dir_n;
      edge_q  <= edge_n;
      mask_q  <= mask_n;
      pen_q   <= pen_n;
      pins_q  <= dout_n & ~dir_n;
      rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign rdata    = rdata_q;
  assign pins_out = pins_q;

  // R4
  out_off_for_inputs_chk: assert property (@(posedge clk) disable iff (rst)
    (pins_out & dir_q) == '0);

  // R9
  narrow_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bus_wide) |=> ($stable(mask_q) && $stable(dout_q) && $stable(dir_q)));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && bus_wide) |=> (rdata == '0));

endmodule

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;

  localparam int NPINS  = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0, bus_wide = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [NPINS-1:0]  wdata = '0;
  logic [NPINS-1:0]  rdata;
  logic [NPINS-1:0]  pins_in = '0;
  logic [NPINS-1:0]  pins_out;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_port #(.NPINS(NPINS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_wide(bus_wide),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pins_in(pins_in), .pins_out(pins_out), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_dout, m_dir, m_edge, m_mask, m_pen, m_stat, m_rdata, m_pins;
  logic        m_irq;
  logic [15:0] hist [$];

  initial begin
    hist = '{16'h0, 16'h0, 16'h0, 16'h0};
  end

  always @(posedge clk) begin
    logic [15:0] cur, old, ev, rd, clr;
    if (rst) begin
      m_dout = 16'hFFFF; m_dir = 16'hFFFF; m_edge = 16'hFFFF;
      m_mask = 16'hFFFF; m_pen = 16'hFFFF; m_stat = 16'h0;
      m_rdata = 16'h0; m_pins = 16'h0; m_irq = 1'b0;
      hist = '{16'h0, 16'h0, 16'h0, 16'h0};
    end else begin
      cur = hist[1];
      old = hist[2];
      ev  = 16'h0;
      for (int i = 0; i < 16; i++) begin
        if (m_dir[i] && !m_mask[i]) begin
          if (m_edge[i] && cur[i] && !old[i]) ev[i] = 1'b1;
          if (!m_edge[i] && !cur[i] && old[i]) ev[i] = 1'b1;
        end
      end
      rd = 16'h0;
      if (rd_en && bus_wide) begin
        case (addr)
          8'h00: rd = hist[1] & m_pen;
          8'h04: rd = m_dout;
          8'h08: rd = m_dir;
          8'h0C: rd = m_edge;
          8'h10: rd = m_mask;
          8'h14: rd = m_stat;
          8'h18: rd = m_pen;
          default: rd = 16'h0;
        endcase
      end
      m_rdata = rd;
      clr = (wr_en && bus_wide && addr == 8'h14) ? wdata : 16'h0;
      m_stat = (m_stat & ~clr) | ev;
      if (wr_en && bus_wide) begin
        case (addr)
          8'h04: m_dout = wdata;
          8'h08: m_dir  = wdata;
          8'h0C: m_edge = wdata;
          8'h10: m_mask = wdata;
          8'h18: m_pen  = wdata;
          default: ;
        endcase
      end
      m_pins = m_dout & ~m_dir;
      m_irq  = |m_stat;
      hist.push_front(pins_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pins_out !== m_pins) begin
        errors++;
        $display("FAIL R4 model pins_out act=%h exp=%h", pins_out, m_pins);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R7 model irq act=%b exp=%b", irq, m_irq);
      end
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL R10 model rdata act=%h exp=%h", rdata, m_rdata);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic wide);
    addr = a; wdata = d; bus_wide = wide; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic wide,
                          input logic [15:0] exp, input string tag);
    addr = a; bus_wide = wide; rd_en = 1'b1;
    @(negedge clk);
    check(tag, rdata, exp);
    rd_en = 1'b0; bus_wide = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(1);

    // R1 reset state
    check("R1 pins_out", pins_out, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    bus_read(8'h04, 1, 16'hFFFF, "R1 dout");
    bus_read(8'h08, 1, 16'hFFFF, "R1 dir");
    bus_read(8'h0C, 1, 16'hFFFF, "R1 edge");
    bus_read(8'h10, 1, 16'hFFFF, "R1 mask");
    bus_read(8'h18, 1, 16'hFFFF, "R1 pen");
    bus_read(8'h14, 1, 16'h0000, "R1 status");
    bus_read(8'h00, 1, 16'h0000, "R1 din");

    // R4 outputs follow data and direction
    bus_write(8'h04, 16'hA5C3, 1);
    bus_write(8'h08, 16'h00FF, 1);
    check("R4 pins after dir 00FF", pins_out, 16'hA500);
    bus_write(8'h08, 16'h0F0F, 1);
    check("R4 pins after dir 0F0F", pins_out, 16'hA0C0);

    // R3 data input gated by pin enable
    pins_in = 16'h1234;
    wait_cycles(3);
    bus_read(8'h00, 1, 16'h1234, "R3 din full");
    bus_write(8'h00, 16'hFFFF, 1);
    bus_read(8'h00, 1, 16'h1234, "R3 din write ignored");
    bus_write(8'h18, 16'h00FF, 1);
    bus_read(8'h00, 1, 16'h0034, "R3 din gated");

    // R2 unmapped offsets
    bus_write(8'h1C, 16'h5555, 1);
    bus_read(8'h1C, 1, 16'h0000, "R2 unmapped 1C");
    bus_read(8'h02, 1, 16'h0000, "R2 unmapped 02");
    bus_read(8'h04, 1, 16'hA5C3, "R2 dout untouched");

    // R9 narrow accesses
    bus_write(8'h10, 16'h0000, 0);
    bus_read(8'h10, 1, 16'hFFFF, "R9 narrow write ignored");
    bus_read(8'h04, 0, 16'h0000, "R9 narrow read zero");

    // edge setup
    pins_in = 16'h0000;
    wait_cycles(4);
    bus_write(8'h18, 16'hFFFF, 1);
    bus_write(8'h08, 16'hFFFF, 1);
    bus_write(8'h0C, 16'hFFFD, 1);
    bus_write(8'h10, 16'h0000, 1);
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0000, "R5 quiet status");

    // R5 rising on bit0, exact latency
    pins_in = 16'h0001;
    wait_cycles(2);
    check("R5 not yet", {15'h0, irq}, 16'h0);
    wait_cycles(1);
    check("R5 third edge irq", {15'h0, irq}, 16'h1);
    bus_read(8'h14, 1, 16'h0001, "R5 rise status");
    bus_write(8'h14, 16'h0001, 1);
    bus_read(8'h14, 1, 16'h0000, "R7 cleared");
    check("R7 irq low", {15'h0, irq}, 16'h0);

    // R5 falling on bit1
    pins_in = 16'h0003;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0000, "R5 rise on falling pin");
    pins_in = 16'h0001;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0002, "R5 fall status");
    pins_in = 16'h0000;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0002, "R5 fall on rising pin");

    // R7 partial clears
    bus_write(8'h14, 16'h0000, 1);
    bus_read(8'h14, 1, 16'h0002, "R7 zero write keeps");
    bus_write(8'h14, 16'hFFFD, 1);
    bus_read(8'h14, 1, 16'h0002, "R7 other bits keep");
    check("R7 irq held", {15'h0, irq}, 16'h1);
    bus_write(8'h14, 16'h0002, 1);
    check("R7 irq drops", {15'h0, irq}, 16'h0);

    // R6 masked and output pins
    bus_write(8'h10, 16'h0004, 1);
    pins_in = 16'h0004;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0000, "R6 masked pin");
    bus_write(8'h08, 16'hFFF7, 1);
    pins_in = 16'h000C;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0000, "R6 output pin");

    // R8 event and clear on the same edge
    pins_in = 16'h001C;
    wait_cycles(4);
    bus_read(8'h14, 1, 16'h0010, "R8 setup set");
    pins_in = 16'h000C;
    wait_cycles(4);
    pins_in = 16'h001C;
    wait_cycles(2);
    bus_write(8'h14, 16'h0010, 1);
    bus_read(8'h14, 1, 16'h0010, "R8 event wins");
    check("R8 irq", {15'h0, irq}, 16'h1);
    bus_write(8'h14, 16'h0010, 1);
    bus_read(8'h14, 1, 16'h0000, "R8 later clear");

    wait_cycles(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule